// File: doc/BRIEF.md
# Processor Status Word with Arithmetic Flag Update

This block holds the 8-bit processor status word of a small CPU core. On each cycle it takes the operation code of the ALU operation under way, the two operands, the ALU result, the operand size and the current accumulator value. From these it computes the next values of the carry, auxiliary carry, overflow and parity flags and registers them. The ALU itself, the instruction decoder and the register file storage sit outside the block.

The word also holds two software flags and a two-bit register bank select. The bank select drives a base-address output that the register file adds to a register number to reach the active group of eight registers. Software reads and writes the word through a byte-wide special-function-register port at one fixed address. A software write takes priority over a flag update that lands in the same cycle.

Top module: `psw_flag_reg`

## Requirements
- R1: After reset the word reads 00h. Its bit layout, from bit 7 down, is carry (7), auxiliary carry (6), software flag A (5), bank select high (4), bank select low (3), overflow (2), software flag B (1), parity (0).
- R2: For op codes 1 (add) and 2 (add with carry) the carry becomes the carry out of the most significant bit of the selected width. Op code 2 also adds the current carry. Size codes: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits.
- R3: For op codes 3 (subtract), 4 (subtract with borrow) and 5 (compare) the carry becomes the borrow into the most significant bit of the selected width. Op code 4 also subtracts the current carry.
- R4: For op codes 1 to 5 at size 0, the auxiliary carry becomes the carry out of bit 3 (add) or the borrow into bit 3 (subtract or compare). At sizes 1 to 3 it keeps its value.
- R5: For op codes 1 to 5 the overflow flag is set exactly when the two's-complement result does not fit the selected width.
- R6: Op code 6 (multiply) sets overflow when the unsigned product of the width-masked operands exceeds the selected width. Op code 7 (divide) sets overflow when the width-masked divisor (second operand) is zero. Both clear the carry and keep the auxiliary carry.
- R7: Bit 0 equals the XOR of the eight accumulator bits sampled on the previous clock edge.
- R8: The bank base output equals 8 times the bank select field: 00h, 08h, 10h or 18h.
- R9: Bits 5 and 1 change only through software writes.
- R10: A software write in the same cycle as a flag update loads all eight bits from the write data.
- R11: Op code 0 and op codes 8 to 15 leave carry, auxiliary carry and overflow unchanged.
- R12: The port reads the word when the address is D0h and reads 00h at any other address. Writes to any other address leave the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_op | input | 4 | Operation code of the current ALU operation |
| op_size | input | 2 | Operand size code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (divisor for divide) |
| alu_res | input | 32 | ALU result for add, subtract and compare |
| acc | input | 8 | Current accumulator value |
| sfr_addr | input | 8 | Special-function-register address |
| sfr_we | input | 1 | Special-function-register write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational |
| psw | output | 8 | Registered status word |
| bank_base | output | 8 | Base address of the active register bank |

## Verification
Every flag, including parity, is registered once. A flag takes the value computed from the inputs that are present at one rising edge, and it shows on `psw` right after that edge. The read data and the bank base follow the register combinationally, so they are due in the same cycle as the word. The bench changes its inputs on the falling edge and compares on the next falling edge, which is exactly one register stage later. A reference model tracks the previous carry for add with carry and subtract with borrow, and also the parity of the accumulator value driven in that cycle.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
    localparam logic [3:0] OP_NONE = 4'd0;
    localparam logic [3:0] OP_ADD  = 4'd1;
    localparam logic [3:0] OP_ADDC = 4'd2;
    localparam logic [3:0] OP_SUB  = 4'd3;
    localparam logic [3:0] OP_SUBB = 4'd4;
    localparam logic [3:0] OP_CMP  = 4'd5;
    localparam logic [3:0] OP_MUL  = 4'd6;
    localparam logic [3:0] OP_DIV  = 4'd7;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef struct packed {
        logic       cy;
        logic       ac;
        logic       uf_a;
        logic [1:0] bank;
        logic       ov;
        logic       uf_b;
        logic       par;
    } psw_t;
endpackage

// File: rtl/psw_arith_flags.sv
`timescale 1ns/1ps
module psw_arith_flags
    import psw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic              cy_in,
    output logic              cy_new,
    output logic              ac_new,
    output logic              ov_new,
    output logic              cy_upd,
    output logic              ac_upd,
    output logic              ov_upd
);
    localparam int IDX_W  = $clog2(DATA_W + 1);
    localparam int SIDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0]   mask;
    logic [IDX_W-1:0]    top_idx;
    logic [SIDX_W-1:0]   sgn_idx;
    logic [DATA_W-1:0]   a_m, b_m;
    logic                cin;
    logic [DATA_W:0]     sum, dif;
    logic [4:0]          nib_sum, nib_dif;
    logic [2*DATA_W-1:0] prod;
    logic                sa, sb, sr;
    logic                is_add, is_sub;

    always_comb begin
        case (size)
            SZ_BYTE: begin mask = DATA_W'(8'hFF);    top_idx = IDX_W'(8);  end
            SZ_WORD: begin mask = DATA_W'(16'hFFFF); top_idx = IDX_W'(16); end
            default: begin mask = '1;                top_idx = IDX_W'(DATA_W); end
        endcase
        sgn_idx = SIDX_W'(top_idx - IDX_W'(1));
        a_m     = a & mask;
        b_m     = b & mask;
        is_add  = (op == OP_ADD) || (op == OP_ADDC);
        is_sub  = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_CMP);
        cin     = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_in : 1'b0;

        sum     = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
        dif     = {1'b0, a_m} - {1'b0, b_m} - {{DATA_W{1'b0}}, cin};
        nib_sum = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
        nib_dif = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, cin};
        prod    = {{DATA_W{1'b0}}, a_m} * {{DATA_W{1'b0}}, b_m};

        sa = a[sgn_idx];
        sb = b[sgn_idx];
        sr = res[sgn_idx];

        cy_new = 1'b0;
        ac_new = 1'b0;
        ov_new = 1'b0;
        cy_upd = 1'b0;
        ac_upd = 1'b0;
        ov_upd = 1'b0;
        if (is_add) begin
            cy_upd = 1'b1;
            ov_upd = 1'b1;
            ac_upd = (size == SZ_BYTE);
            cy_new = sum[top_idx];
            ac_new = nib_sum[4];
            ov_new = (sa == sb) && (sr != sa);
        end else if (is_sub) begin
            cy_upd = 1'b1;
            ov_upd = 1'b1;
            ac_upd = (size == SZ_BYTE);
            cy_new = dif[top_idx];
            ac_new = nib_dif[4];
            ov_new = (sa != sb) && (sr != sa);
        end else if (op == OP_MUL) begin
            cy_upd = 1'b1;
            ov_upd = 1'b1;
            ov_new = |(prod >> top_idx);
        end else if (op == OP_DIV) begin
            cy_upd = 1'b1;
            ov_upd = 1'b1;
            ov_new = (b_m == '0);
        end
    end
endmodule

// File: rtl/psw_parity.sv
`timescale 1ns/1ps
module psw_parity #(
    parameter int ACC_W = 8
) (
    input  logic [ACC_W-1:0] acc,
    output logic             odd
);
    logic [ACC_W:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < ACC_W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ acc[i];
    end
    assign odd = chain[ACC_W];
endmodule

// File: rtl/psw_bank_map.sv
`timescale 1ns/1ps
module psw_bank_map #(
    parameter int BANK_REGS = 8,
    parameter int ADDR_W    = 8
) (
    input  logic [1:0]        bank_sel,
    output logic [ADDR_W-1:0] base
);
    localparam int SHIFT = $clog2(BANK_REGS);

    assign base = ADDR_W'(bank_sel) << SHIFT;
endmodule

// File: rtl/psw_flag_reg.sv
`timescale 1ns/1ps
module psw_flag_reg
    import psw_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ACC_W     = 8,
    parameter int          BANK_REGS = 8,
    parameter logic [7:0]  SFR_ADDR  = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        alu_op,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [ACC_W-1:0]  acc,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output logic [7:0]        psw,
    output logic [7:0]        bank_base
);
    psw_t state_d, state_q;
    logic cy_new, ac_new, ov_new;
    logic cy_upd, ac_upd, ov_upd;
    logic acc_odd;
    logic sfr_hit;

    psw_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .op     (alu_op),
        .size   (op_size),
        .a      (opa),
        .b      (opb),
        .res    (alu_res),
        .cy_in  (state_q.cy),
        .cy_new (cy_new),
        .ac_new (ac_new),
        .ov_new (ov_new),
        .cy_upd (cy_upd),
        .ac_upd (ac_upd),
        .ov_upd (ov_upd)
    );

    psw_parity #(.ACC_W(ACC_W)) u_parity (
        .acc (acc),
        .odd (acc_odd)
    );

    psw_bank_map #(.BANK_REGS(BANK_REGS), .ADDR_W(8)) u_bank (
        .bank_sel (state_q.bank),
        .base     (bank_base)
    );

    assign sfr_hit = (sfr_addr == SFR_ADDR);

    always_comb begin
        state_d     = state_q;
        state_d.par = acc_odd;
        if (cy_upd) state_d.cy = cy_new;
        if (ac_upd) state_d.ac = ac_new;
        if (ov_upd) state_d.ov = ov_new;
        if (sfr_we && sfr_hit) state_d = psw_t'(sfr_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign psw       = state_q;
    assign sfr_rdata = sfr_hit ? state_q : 8'h00;
endmodule

// File: rtl/psw_flag_reg_chk.sv
`timescale 1ns/1ps
module psw_flag_reg_chk #(
    parameter logic [7:0] SFR_ADDR = 8'hD0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  alu_op,
    input logic [1:0]  op_size,
    input logic [31:0] opb,
    input logic [7:0]  acc,
    input logic [7:0]  sfr_addr,
    input logic        sfr_we,
    input logic [7:0]  sfr_wdata,
    input logic [7:0]  psw,
    input logic [7:0]  bank_base
);
    logic wr_hit;
    logic b_zero;
    logic arith_op;

    assign wr_hit   = sfr_we && (sfr_addr == SFR_ADDR);
    assign arith_op = (alu_op >= 4'd1) && (alu_op <= 4'd7);
    always_comb begin
        case (op_size)
            2'd0:    b_zero = (opb[7:0] == 8'h00);
            2'd1:    b_zero = (opb[15:0] == 16'h0000);
            default: b_zero = (opb == 32'h0);
        endcase
    end

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> psw == 8'h00);

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> psw == $past(sfr_wdata));

    a_r7_parity_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> psw[0] == ^$past(acc));

    a_r9_user_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(psw[5]) && $stable(psw[1]) && $stable(psw[4:3]));

    a_r11_other_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !arith_op) |=> $stable(psw[7]) && $stable(psw[6]) && $stable(psw[2]));

    a_r4_wide_ac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && op_size != 2'd0) |=> $stable(psw[6]));

    a_r6_div_zero_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && alu_op == 4'd7 && b_zero) |=> psw[2] && !psw[7]);

    a_r8_bank_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(psw[4:3]) |-> $stable(bank_base));
endmodule

bind psw_flag_reg psw_flag_reg_chk #(.SFR_ADDR(SFR_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_op    (alu_op),
    .op_size   (op_size),
    .opb       (opb),
    .acc       (acc),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .psw       (psw),
    .bank_base (bank_base)
);

// File: tb/psw_flag_reg_tb.sv
`timescale 1ns/1ps
module psw_flag_reg_tb_top;
    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  acc;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd1, 2'd0, 32'h000000FF, 32'h00000001, 8'h01},
        '{4'd1, 2'd0, 32'h0000007F, 32'h00000001, 8'h03},
        '{4'd1, 2'd0, 32'h00000008, 32'h00000008, 8'h07},
        '{4'd2, 2'd0, 32'h000000FE, 32'h00000001, 8'h00},
        '{4'd3, 2'd0, 32'h00000000, 32'h00000001, 8'hFF},
        '{4'd3, 2'd0, 32'h00000080, 32'h00000001, 8'h80},
        '{4'd4, 2'd0, 32'h00000010, 32'h00000001, 8'h11},
        '{4'd5, 2'd1, 32'h00001234, 32'h00004321, 8'h12},
        '{4'd1, 2'd1, 32'h0000FFFF, 32'h00000001, 8'h34},
        '{4'd1, 2'd2, 32'hFFFFFFFF, 32'h00000001, 8'h56},
        '{4'd3, 2'd2, 32'h80000000, 32'h00000001, 8'h78},
        '{4'd6, 2'd0, 32'h00000010, 32'h00000010, 8'h9A},
        '{4'd6, 2'd0, 32'h0000000F, 32'h00000011, 8'hBC},
        '{4'd6, 2'd1, 32'h00010100, 32'h00000100, 8'hDE},
        '{4'd7, 2'd0, 32'h00000055, 32'h00000300, 8'hF0},
        '{4'd7, 2'd1, 32'h00000055, 32'h00000003, 8'h0F},
        '{4'd9, 2'd0, 32'h000000FF, 32'h000000FF, 8'h55},
        '{4'd0, 2'd3, 32'h7FFFFFFF, 32'h7FFFFFFF, 8'hAA}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  alu_op = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] opa = '0, opb = '0, alu_res = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  sfr_addr = 8'hD0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata, psw, bank_base;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_psw = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psw_flag_reg dut_i (
        .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .op_size(op_size),
        .opa(opa), .opb(opb), .alu_res(alu_res), .acc(acc),
        .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .psw(psw), .bank_base(bank_base)
    );

    function automatic int width_of(logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] res_of(logic [3:0] op, logic [1:0] sz,
                                           logic [31:0] a, logic [31:0] b, logic c);
        longint unsigned m = (64'd1 << width_of(sz)) - 1;
        longint unsigned am = a & m;
        longint unsigned bm = b & m;
        longint unsigned ci = (op == 4'd2 || op == 4'd4) ? longint'(c) : 0;
        if (op == 4'd1 || op == 4'd2) return 32'((am + bm + ci) & m);
        if (op >= 4'd3 && op <= 4'd5) return 32'((am - bm - ci) & m);
        return 32'h0;
    endfunction

    function automatic logic [7:0] ref_next(logic [7:0] cur, logic [3:0] op, logic [1:0] sz,
                                            logic [31:0] a, logic [31:0] b, logic [7:0] av);
        int w = width_of(sz);
        longint unsigned m = (64'd1 << w) - 1;
        longint unsigned am = a & m;
        longint unsigned bm = b & m;
        longint ci = (op == 4'd2 || op == 4'd4) ? longint'(cur[7]) : 0;
        longint sa = longint'(am);
        longint sb = longint'(bm);
        longint smax = (longint'(1) << (w - 1)) - 1;
        longint smin = -(longint'(1) << (w - 1));
        longint sr;
        logic [7:0] nx = cur;
        if (am >= (64'd1 << (w - 1))) sa = sa - (longint'(1) << w);
        if (bm >= (64'd1 << (w - 1))) sb = sb - (longint'(1) << w);
        if (op == 4'd1 || op == 4'd2) begin
            nx[7] = (am + bm + longint'(ci)) > m;
            sr = sa + sb + ci;
            nx[2] = (sr > smax) || (sr < smin);
            if (w == 8) nx[6] = ((am & 15) + (bm & 15) + longint'(ci)) > 15;
        end else if (op >= 4'd3 && op <= 4'd5) begin
            nx[7] = longint'(am) < longint'(bm) + ci;
            sr = sa - sb - ci;
            nx[2] = (sr > smax) || (sr < smin);
            if (w == 8) nx[6] = longint'(am & 15) < longint'(bm & 15) + ci;
        end else if (op == 4'd6) begin
            nx[7] = 1'b0;
            nx[2] = (am * bm) > m;
        end else if (op == 4'd7) begin
            nx[7] = 1'b0;
            nx[2] = (bm == 0);
        end
        nx[0] = ^av;
        return nx;
    endfunction

    task automatic check8(string tag, logic [7:0] got, logic [7:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, want);
        end
    endtask

    task automatic apply(string tag, logic [3:0] op, logic [1:0] sz,
                         logic [31:0] a, logic [31:0] b, logic [7:0] av);
        alu_op  = op;
        op_size = sz;
        opa     = a;
        opb     = b;
        acc     = av;
        alu_res = res_of(op, sz, a, b, exp_psw[7]);
        sfr_we  = 1'b0;
        exp_psw = ref_next(exp_psw, op, sz, a, b, av);
        @(negedge clk);
        check8(tag, psw, exp_psw);
    endtask

    task automatic sw_write(logic [7:0] addr, logic [7:0] data);
        alu_op    = 4'd0;
        sfr_addr  = addr;
        sfr_wdata = data;
        sfr_we    = 1'b1;
        if (addr == 8'hD0) exp_psw = data;
        else exp_psw[0] = ^acc;
        @(negedge clk);
        sfr_we   = 1'b0;
        sfr_addr = 8'hD0;
    endtask

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd1, 4'd2:       return "R2 R4 R5 add";
            4'd3, 4'd4, 4'd5: return "R3 R4 R5 sub";
            4'd6, 4'd7:       return "R6 mul/div";
            default:          return "R11 other op";
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, readback at D0h
        check8("R1 reset psw", psw, 8'h00);
        check8("R1 reset readback", sfr_rdata, 8'h00);
        check8("R8 reset bank base", bank_base, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(tag_of(VECS[i].op), VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b, VECS[i].acc);
        end

        // randomized operands for every op and size
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  op = 4'($urandom_range(1, 7));
            logic [1:0]  sz = 2'($urandom_range(0, 3));
            logic [31:0] a  = $urandom;
            logic [31:0] b  = $urandom;
            if (op == 4'd7 && ($urandom_range(0, 3) == 0)) b = 32'h0;
            apply(tag_of(op), op, sz, a, b, 8'($urandom));
        end

        // R8 / R12: bank select 0..3 via software
        for (int k = 0; k < 4; k++) begin
            sw_write(8'hD0, 8'(k << 3));
            check8("R8 bank base", bank_base, 8'(k * 8));
            check8("R12 readback", sfr_rdata, 8'(k << 3));
        end

        // R12: write to another address is ignored, reads zero there
        acc = 8'h01;
        sw_write(8'hD1, 8'hFF);
        check8("R12 foreign write ignored", psw, exp_psw);
        sfr_addr = 8'hD1;
        #1;
        check8("R12 foreign read zero", sfr_rdata, 8'h00);
        sfr_addr = 8'hD0;

        // R9: software flags survive many operations
        sw_write(8'hD0, 8'h22);
        for (int i = 0; i < 20; i++) begin
            apply("R9 user flags", 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                  $urandom, $urandom, 8'($urandom));
        end
        check8("R9 flags A and B", psw & 8'h22, 8'h22);

        // R4: wide operation keeps AC
        sw_write(8'hD0, 8'h40);
        apply("R4 wide AC hold", 4'd1, 2'd1, 32'h0000000F, 32'h00000001, 8'h00);
        check8("R4 AC still set", psw & 8'h40, 8'h40);

        // R10: write wins over a same-cycle add
        alu_op    = 4'd1;
        op_size   = 2'd0;
        opa       = 32'hFF;
        opb       = 32'h01;
        alu_res   = 32'h00;
        acc       = 8'h07;
        sfr_wdata = 8'h18;
        sfr_we    = 1'b1;
        exp_psw   = 8'h18;
        @(negedge clk);
        sfr_we = 1'b0;
        check8("R10 write priority", psw, 8'h18);
        check8("R8 bank 3 base", bank_base, 8'h18);

        // R7: parity tracks the accumulator with no ALU op
        apply("R7 parity odd", 4'd0, 2'd0, 32'h0, 32'h0, 8'h01);
        apply("R7 parity even", 4'd0, 2'd0, 32'h0, 32'h0, 8'h03);
        apply("R7 parity all ones", 4'd0, 2'd0, 32'h0, 32'h0, 8'hFF);
        apply("R7 parity seven", 4'd12, 2'd0, 32'h0, 32'h0, 8'hFE);

        // R6: divide by zero at each size
        apply("R6 div zero byte", 4'd7, 2'd0, 32'h12, 32'hFF00, 8'h00);
        check8("R6 OV set byte", psw & 8'h84, 8'h04);
        apply("R6 div nonzero word", 4'd7, 2'd1, 32'h12, 32'h00010002, 8'h00);
        check8("R6 OV clear word", psw & 8'h04, 8'h00);
        apply("R6 div zero dword", 4'd7, 2'd2, 32'h12, 32'h0, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule